// File: doc/BRIEF.md
# Framed Serial DAC Writer

This block takes one output sample at a time over a valid/ready stream and writes it to a serial digital-to-analog converter. Each write is a frame. The active-low frame select is pulled low, sixteen bits are shifted out most significant bit first, and then the frame select is released. The rising edge of the frame select is what makes the converter latch the new value.

The 14-bit sample takes the low bits of a 16-bit word. A fixed 2-bit mode field, which is zero for normal output, fills the top two bits. The serial clock is made from the system clock by a divider whose setting comes in on a plain input and is captured when the sample is accepted. Data changes on the rising edge of the serial clock, so it is steady when the converter samples it on the falling edge. The serial clock rests high whenever no frame is in progress. The block holds one sample at a time. Back-pressure is simple: `in_ready` is high only while the block is idle. A producer holds `in_valid` and `in_sample` until a clock edge on which both `in_valid` and `in_ready` are high. Anything on the input while `in_ready` is low is not taken.

Top module: `sdac_frame_writer`

## Requirements
- R1: After reset, `dac_sync_n` is 1, `dac_sclk` is 1, `in_ready` is 1, `busy` is 0 and `done` is 0.
- R2: The frame word is {MODE_FIELD (2 bits, default 2'b00), in_sample[13:0]}. Bit 15 is sent first and bit 0 last, so the high byte goes out before the low byte.
- R3: Each frame has exactly 16 falling edges of `dac_sclk` while `dac_sync_n` is low.
- R4: Let H be `cfg_div`+1 system clock cycles. Every half period of `dac_sclk` inside a frame lasts H cycles. `dac_sync_n` falls H cycles before the first falling edge of `dac_sclk`. `dac_sync_n` rises H cycles after the 16th falling edge, in the same cycle as the last rising edge of `dac_sclk`.
- R5: Inside a frame, `dac_sdata` changes only in a cycle where `dac_sclk` rises. It never changes in a cycle where `dac_sclk` falls.
- R6: `dac_sclk` is high whenever `dac_sync_n` is high.
- R7: `in_ready` is low from the accepting edge until 2H cycles after `dac_sync_n` rises. `busy` is its inverse. Consecutive frames are separated by at least 2H cycles of `dac_sync_n` high.
- R8: `done` is high for exactly one cycle, the cycle in which `dac_sync_n` rises.
- R9: A change of `in_sample` or a pulse on `in_valid` while `in_ready` is low has no effect on the word being sent.
- R10: The divider value is captured on the accepting edge. A change of `cfg_div` during a frame does not alter that frame's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Half period of the serial clock in system cycles, minus one |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block idle and able to take a sample |
| in_sample | input | SAMPLE_W | Sample value |
| dac_sync_n | output | 1 | Active-low frame select; its rising edge latches the word |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_sdata | output | 1 | Serial data, MSB first |
| busy | output | 1 | Frame or inter-frame gap in progress |
| done | output | 1 | One-cycle pulse when the word is latched |

## Verification
The bench builds the block with a 4-bit divider field and sweeps `cfg_div` from 0 to 3, so half periods of one to four system cycles are all covered. Those include the single-cycle half period, where ticks come every cycle. At each setting it streams a spread of samples back to back, including all zeros, all ones and walking ones. This exercises the shortest allowed gap between frames and every bit position of the word. A separate frame changes `in_sample` and `cfg_div` and pulses `in_valid` while the block is busy, to show that none of these reach the wire.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_GAP   = 2'd2
  } sdac_state_e;
endpackage

// File: rtl/sdac_half_tick.sv
module sdac_half_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_q,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == div_q) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  // R4: the phase count never passes the captured half-period limit
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= div_q);
endmodule

// File: rtl/sdac_shift_reg.sv
module sdac_shift_reg #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift,
  output logic              msb
);
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh <= '0;
    else if (load)  sh <= load_word;
    else if (shift) sh <= {sh[WORD_W-2:0], 1'b0};
  end

  assign msb = sh[WORD_W-1];

  // R5: a shift and a load never coincide
  p_load_shift_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift));
endmodule

// File: rtl/sdac_frame_writer.sv
module sdac_frame_writer
  import sdac_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int MODE_W   = 2,
  parameter logic [MODE_W-1:0] MODE_FIELD = '0,
  parameter int DIV_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                dac_sync_n,
  output logic                dac_sclk,
  output logic                dac_sdata,
  output logic                busy,
  output logic                done
);
  localparam int WORD_W    = MODE_W + SAMPLE_W;
  localparam int LAST_EDGE = 2 * WORD_W - 1;
  localparam int EDGE_W    = $clog2(2 * WORD_W);
  localparam logic [EDGE_W-1:0] LAST_E = EDGE_W'(LAST_EDGE);
  localparam logic [EDGE_W-1:0] GAP_E  = EDGE_W'(1);

  sdac_state_e       state;
  logic [EDGE_W-1:0] edge_cnt;
  logic [DIV_W-1:0]  div_q;
  logic              sclk_q, sync_q, done_q;
  logic              tick, accept, shift_en;
  logic [WORD_W-1:0] word;

  assign word     = {MODE_FIELD, in_sample};
  assign accept   = in_valid && (state == ST_IDLE);
  assign shift_en = (state == ST_FRAME) && tick && !sclk_q && (edge_cnt != LAST_E);

  sdac_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state != ST_IDLE),
    .div_q (div_q),
    .tick  (tick)
  );

  sdac_shift_reg #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_word (word),
    .shift     (shift_en),
    .msb       (dac_sdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      edge_cnt <= '0;
      div_q    <= '0;
      sclk_q   <= 1'b1;
      sync_q   <= 1'b1;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_FRAME;
          sync_q   <= 1'b0;
          edge_cnt <= '0;
          div_q    <= cfg_div;
        end
        ST_FRAME: if (tick) begin
          sclk_q <= ~sclk_q;
          if (edge_cnt == LAST_E) begin
            sync_q   <= 1'b1;
            done_q   <= 1'b1;
            state    <= ST_GAP;
            edge_cnt <= '0;
          end else begin
            edge_cnt <= edge_cnt + 1'b1;
          end
        end
        ST_GAP: if (tick) begin
          if (edge_cnt == GAP_E) begin
            state    <= ST_IDLE;
            edge_cnt <= '0;
          end else begin
            edge_cnt <= edge_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dac_sclk   = sclk_q;
  assign dac_sync_n = sync_q;
  assign done       = done_q;
  assign in_ready   = (state == ST_IDLE);
  assign busy       = (state != ST_IDLE);

  // R6: the serial clock rests high outside a frame
  p_sclk_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dac_sync_n |-> dac_sclk);
  // R5: data is steady across the converter's capture edge
  p_sdata_stable_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_sclk) |-> $stable(dac_sdata));
  // R8: done marks the latch edge of the frame select
  p_done_at_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(dac_sync_n));
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: no acceptance while a frame is open
  p_ready_low_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_sync_n |-> !in_ready);
  // R7: a frame only opens from an accepted handshake
  p_sync_fall_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_sync_n) |-> $past(in_valid && in_ready));
endmodule

// File: tb/tb_sdac_frame_writer.sv
module tb_sdac_frame_writer;
  localparam int SW = 14;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] cfg_div = '0;
  logic in_valid = 1'b0;
  logic [SW-1:0] in_sample = '0;
  logic in_ready, dac_sync_n, dac_sclk, dac_sdata, busy, done;

  int checks = 0, fails = 0;
  int cur_h = 1;
  logic [15:0] exp_word = '0;
  bit finished = 0;

  always #4 clk = ~clk;

  sdac_frame_writer #(.SAMPLE_W(SW), .DIV_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .in_valid(in_valid),
    .in_ready(in_ready), .in_sample(in_sample), .dac_sync_n(dac_sync_n),
    .dac_sclk(dac_sclk), .dac_sdata(dac_sdata), .busy(busy), .done(done));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // converter model and timing monitor, sampled at falling clk edges
  logic p_sync = 1'b1, p_sclk = 1'b1, p_sdata = 1'b0;
  logic [15:0] cap = '0;
  int bits = 0, since = 0, frame_h = 1, prev_h = 1, hi_len = 0, gap_cnt = 0;
  bit in_frame = 0, gap_act = 0, seen_frame = 0, ready_bad = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (in_frame) since++;
      if (p_sync && !dac_sync_n) begin
        if (seen_frame) chk(hi_len >= 2 * prev_h, "R7 sync-high gap", hi_len, 2 * prev_h);
        in_frame = 1; bits = 0; cap = '0; since = 0; frame_h = cur_h; ready_bad = 0;
        gap_act = 0;
      end else if (in_frame) begin
        if (dac_sdata !== p_sdata && !(!p_sclk && dac_sclk))
          chk(0, "R5 data moved off rising edge", dac_sdata, p_sdata);
        if (dac_sclk !== p_sclk) begin
          chk(since == frame_h, "R4 half period", since, frame_h);
          since = 0;
          if (p_sclk && !dac_sclk) begin
            cap = {cap[14:0], dac_sdata};
            bits++;
          end
        end
        if (in_ready) ready_bad = 1;
        if (dac_sync_n) begin
          in_frame = 0;
          chk(dac_sclk && !p_sclk, "R4 sync rises with last sclk rise", dac_sclk, 1);
          chk(bits == 16, "R3 falling edges per frame", bits, 16);
          chk(cap == exp_word, "R2 latched word", cap, exp_word);
          chk(done == 1'b1, "R8 done at latch", done, 1);
          chk(!ready_bad, "R7 ready low in frame", ready_bad, 0);
          prev_h = frame_h; hi_len = 0; gap_cnt = 0; gap_act = 1; seen_frame = 1;
        end
      end else begin
        if (dac_sync_n) hi_len++;
        if (gap_act) begin
          gap_cnt++;
          if (in_ready) begin
            chk(gap_cnt == 2 * prev_h, "R7 ready return", gap_cnt, 2 * prev_h);
            gap_act = 0;
          end
        end
        if (done) chk(0, "R8 stray done", done, 0);
      end
      if (dac_sync_n && !dac_sclk) chk(0, "R6 sclk low while idle", dac_sclk, 1);
      if (busy === in_ready) chk(0, "R7 busy inverse of ready", busy, !in_ready);
      p_sync = dac_sync_n; p_sclk = dac_sclk; p_sdata = dac_sdata;
    end
  end

  task automatic send(input logic [SW-1:0] s, input int div);
    @(negedge clk);
    in_valid = 1'b1; in_sample = s; cfg_div = DW'(div);
    while (!in_ready) @(negedge clk);
    cur_h = div + 1; exp_word = {2'b00, s};
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(dac_sync_n == 1 && dac_sclk == 1 && in_ready == 1 && busy == 0 && done == 0,
        "R1 reset state", {dac_sync_n, dac_sclk, in_ready, busy, done}, 5'b11100);
    rst_n = 1'b1;
    for (int d = 0; d < 4; d++) begin
      send(14'h0000, d);
      send(14'h3FFF, d);
      for (int b = 0; b < SW; b++) send(14'(1 << b), d);
      for (int k = 1; k < 6; k++) send(14'((k * 16'h0B37) & 16'h3FFF), d);
    end
    // R9 and R10: disturb inputs during a frame
    send(14'h2A5C, 1);
    repeat (5) @(negedge clk);
    in_sample = 14'h1111; cfg_div = 4'd3; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    while (!in_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(dac_sync_n == 1'b1, "R9 no frame from busy-time valid", dac_sync_n, 1);
    send(14'h0155, 2);
    while (!in_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule